// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block turns an asynchronous serial line into received characters. A built-in rate generator derives a sampling tick at sixteen times the bit rate from the system clock, an 8-bit divisor and a speed-range select. Each bit is judged by a three-sample majority vote around its centre. Each frame is a low start bit, 8 or 9 data bits sent least significant first, and one stop bit.

Completed frames go into a two-entry receive queue. The host sees the oldest entry on its outputs and removes it with a one-cycle read strobe. In 9-bit mode an address-filtering option keeps only frames whose ninth bit is 1. This lets a node on a shared multidrop line ignore data meant for other nodes. A bad stop bit is reported with the character it belongs to. A queue overflow locks the receiver until the host drops the receive enable.

Top module: `uart_rx_addr`

## Requirements
- R1: One sampling tick lasts (divisor+1) clock cycles when `high_speed` is 1 and 4·(divisor+1) cycles when it is 0. A bit lasts 16 ticks, so the bit period is 16·(N+1) or 64·(N+1) clock cycles.
- R2: In 8-bit mode (`nine_bit`=0) a frame carries 8 data bits, least significant first. The byte appears on `rx_data`, `rx_ready` rises, and `rx_bit9` reads 0.
- R3: In 9-bit mode (`nine_bit`=1) the bit after the eighth data bit is stored and appears on `rx_bit9` next to its byte.
- R4: With `addr_detect`=1 in 9-bit mode, a frame whose ninth bit is 0 is thrown away and `rx_ready` stays low. A frame whose ninth bit is 1 is queued.
- R5: With `addr_detect`=0, every frame is queued whatever its ninth bit. In 8-bit mode `addr_detect` has no effect.
- R6: A frame whose stop bit samples low is still queued, with `ferr`=1. `ferr` always describes the entry currently shown, so it changes when that entry is read out.
- R7: The queue holds two frames and returns them oldest first. A `rd_strobe` pulse removes the shown entry. A strobe while `rx_ready`=0 changes nothing. While `rx_ready`=1 and no strobe is given, `rx_data` and `rx_bit9` hold.
- R8: A frame that completes while both entries are occupied sets `oerr` and is lost. While `oerr`=1 no frame is received. Only `rx_enable`=0 clears `oerr`, and the queued entries stay readable.
- R9: A falling edge on the line whose majority vote at the start-bit centre reads high is treated as a glitch and starts no frame.
- R10: While `rx_enable`=0 nothing is received and `rx_ready` does not rise.
- R11: After reset `rx_ready`, `ferr` and `oerr` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial line, idles high |
| divisor | input | 8 | Rate divisor N |
| high_speed | input | 1 | 1: tick every N+1 cycles; 0: every 4·(N+1) cycles |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| rx_enable | input | 1 | Receive enable; 0 clears overrun |
| addr_detect | input | 1 | Keep only frames with ninth bit 1 (9-bit mode) |
| rd_strobe | input | 1 | One-cycle pulse removing the shown entry |
| rx_data | output | 8 | Oldest queued byte |
| rx_bit9 | output | 1 | Ninth bit of the oldest entry |
| rx_ready | output | 1 | Queue not empty |
| ferr | output | 1 | Stop-bit error of the oldest entry |
| oerr | output | 1 | Overrun lock |

## Verification
The bench uses the default 8-bit data width and a two-entry queue. It runs at divisor 0 in the high-speed range, so one bit lasts 16 clocks. This makes it cheap to send all 256 byte values and a wide sweep of 9-bit values, with and without address filtering. For the rate law, divisors 0, 1, 2 and 5 are swept in both speed ranges, with the line driven at the bit period the bench computes. The overrun lock, the glitch filter and the enable-clear sequence are each run as complete sequences.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_e;

    localparam int unsigned OVERSAMPLE = 16;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             high_speed,
    output logic             tick
);
    localparam int unsigned CNT_W = DIV_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } baud_st_t;

    baud_st_t st_q, st_d;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = high_speed ? CNT_W'(divisor) : {divisor, 2'b11};
        st_d.tick = (st_q.cnt >= limit);
        st_d.cnt  = st_d.tick ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    input  logic              run,
    input  logic              nine_bit,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_bit9,
    output logic              frm_ferr
);
    localparam int unsigned IDX_W = $clog2(DATA_W + 1);
    localparam logic [3:0]  SUB_A = 4'd7;
    localparam logic [3:0]  SUB_B = 4'd8;
    localparam logic [3:0]  SUB_V = 4'd9;

    typedef struct packed {
        rx_phase_e         phase;
        logic [3:0]        sub;
        logic [IDX_W-1:0]  idx;
        logic              samp_a;
        logic              samp_b;
        logic [DATA_W-1:0] shreg;
        logic              bit9;
        logic [1:0]        sync;
        logic              valid;
        logic              ferr;
    } frame_st_t;

    frame_st_t st_q, st_d;
    logic       rxd;
    logic [3:0] nsub;
    logic       vote;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sync  = {st_q.sync[0], rx_in};
        rxd        = st_q.sync[1];
        nsub       = st_q.sub + 4'd1;
        vote       = vote3(st_q.samp_a, st_q.samp_b, rxd);
        last_idx   = nine_bit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

        if (!run) begin
            st_d.phase = PH_IDLE;
        end else if (tick) begin
            if (st_q.phase == PH_IDLE) begin
                if (!rxd) begin
                    st_d.phase = PH_START;
                    st_d.sub   = 4'd0;
                    st_d.bit9  = 1'b0;
                end
            end else begin
                st_d.sub = nsub;
                if (nsub == SUB_A) st_d.samp_a = rxd;
                if (nsub == SUB_B) st_d.samp_b = rxd;
                if (nsub == SUB_V) begin
                    unique case (st_q.phase)
                        PH_START: begin
                            st_d.phase = vote ? PH_IDLE : PH_DATA;
                            st_d.idx   = '0;
                        end
                        PH_DATA: begin
                            if (st_q.idx < IDX_W'(DATA_W))
                                st_d.shreg = {vote, st_q.shreg[DATA_W-1:1]};
                            else
                                st_d.bit9 = vote;
                            if (st_q.idx == last_idx) st_d.phase = PH_STOP;
                            else                      st_d.idx   = st_q.idx + 1'b1;
                        end
                        PH_STOP: begin
                            st_d.valid = 1'b1;
                            st_d.ferr  = ~vote;
                            st_d.phase = PH_IDLE;
                        end
                        default: st_d.phase = PH_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_valid = st_q.valid;
    assign frm_data  = st_q.shreg;
    assign frm_bit9  = st_q.bit9;
    assign frm_ferr  = st_q.ferr;
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              nine_bit,
    input  logic              addr_detect,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_bit9,
    input  logic              frm_ferr,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rd_ready,
    output logic              rd_ferr,
    output logic              overrun
);
    localparam int unsigned ENT_W = DATA_W + 2;
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            rd_ptr;
        logic [PTR_W-1:0]            wr_ptr;
        logic [CNT_W-1:0]            count;
        logic                        oerr;
    } buf_st_t;

    buf_st_t st_q, st_d;
    logic accept, pop_ok, full_now, write;
    logic [ENT_W-1:0] head;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        accept   = frm_valid && enable && !(addr_detect && nine_bit && !frm_bit9);
        pop_ok   = pop && (st_q.count != '0);
        full_now = (st_q.count == CNT_W'(DEPTH)) && !pop_ok;
        write    = accept && !full_now && !st_q.oerr;

        if (accept && full_now) st_d.oerr = 1'b1;
        if (!enable)            st_d.oerr = 1'b0;

        if (write) begin
            st_d.mem[st_q.wr_ptr] = {frm_ferr, frm_bit9 & nine_bit, frm_data};
            st_d.wr_ptr           = ptr_inc(st_q.wr_ptr);
        end
        if (pop_ok) st_d.rd_ptr = ptr_inc(st_q.rd_ptr);

        case ({write, pop_ok})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head     = st_q.mem[st_q.rd_ptr];
    assign rd_ready = (st_q.count != '0);
    assign rd_data  = head[DATA_W-1:0];
    assign rd_bit9  = head[DATA_W];
    assign rd_ferr  = rd_ready & head[DATA_W+1];
    assign overrun  = st_q.oerr;
endmodule

// File: rtl/uart_rx_addr.sv
module uart_rx_addr #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              high_speed,
    input  logic              nine_bit,
    input  logic              rx_enable,
    input  logic              addr_detect,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_ready,
    output logic              ferr,
    output logic              oerr
);
    logic              tick;
    logic              run;
    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    logic              frm_bit9;
    logic              frm_ferr;

    assign run = rx_enable & ~oerr;

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor),
        .high_speed(high_speed), .tick(tick)
    );

    uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_in(rx_in),
        .run(run), .nine_bit(nine_bit), .frm_valid(frm_valid),
        .frm_data(frm_data), .frm_bit9(frm_bit9), .frm_ferr(frm_ferr)
    );

    uart_rx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .enable(rx_enable), .nine_bit(nine_bit),
        .addr_detect(addr_detect), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_bit9(frm_bit9), .frm_ferr(frm_ferr), .pop(rd_strobe),
        .rd_data(rx_data), .rd_bit9(rx_bit9), .rd_ready(rx_ready),
        .rd_ferr(ferr), .overrun(oerr)
    );
endmodule

// File: rtl/uart_rx_addr_chk.sv
module uart_rx_addr_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              rd_strobe,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              oerr
);
    // R8: the lock persists while reception stays enabled
    p_oerr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr && rx_enable) |=> oerr);

    // R8: dropping the enable releases the lock
    p_oerr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !oerr);

    // R8: overrun only arises with a full queue
    p_oerr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> rx_ready);

    // R7: shown entry holds until read
    p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe) |=> (rx_ready && $stable(rx_data) && $stable(rx_bit9)));

    // R10: a disabled receiver never raises ready
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !rx_ready) |=> !rx_ready);
endmodule

bind uart_rx_addr uart_rx_addr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rd_strobe(rd_strobe),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_bit9(rx_bit9), .oerr(oerr)
);

// File: tb/sim_uart_rx_addr.sv
`timescale 1ns/1ps
module sim_uart_rx_addr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       high_speed = 1'b1;
    logic       nine_bit = 1'b0;
    logic       rx_enable = 1'b1;
    logic       addr_detect = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ready, ferr, oerr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_addr u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .divisor(divisor),
        .high_speed(high_speed), .nine_bit(nine_bit), .rx_enable(rx_enable),
        .addr_detect(addr_detect), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ready(rx_ready), .ferr(ferr), .oerr(oerr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bit_period();
        return (high_speed ? 16 : 64) * (int'(divisor) + 1);
    endfunction

    task automatic send(input logic [8:0] v, input bit nine, input bit stop_ok);
        int per = bit_period();
        @(negedge clk) rx_in = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rx_in = v[i];
            repeat (per) @(negedge clk);
        end
        rx_in = stop_ok;
        repeat (per) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * per) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 ready", rx_ready, 0);
        check("R11 oerr", oerr, 0);
        check("R11 ferr", ferr, 0);
        check("R11 data", rx_data, 0);

        // R7 read while empty has no effect
        do_read();
        check("R7 empty read", {rx_ready, oerr}, 0);

        // R2 all bytes, 8-bit mode
        for (int b = 0; b < 256; b++) begin
            send(9'(b), 1'b0, 1'b1);
            check("R2 frame", {rx_ready, ferr, rx_bit9, rx_data}, {3'b100, 8'(b)});
            do_read();
            check("R2 drained", rx_ready, 0);
        end

        // R1 rate sweep
        for (int hs = 0; hs < 2; hs++) begin
            for (int k = 0; k < 4; k++) begin
                int nv = (k == 3) ? 5 : k;
                high_speed = hs[0];
                divisor = 8'(nv);
                repeat (600) @(negedge clk);
                send(9'((nv * 37 + hs * 91) & 8'hff), 1'b0, 1'b1);
                check("R1 rate", {rx_ready, rx_data}, {1'b1, 8'((nv * 37 + hs * 91) & 8'hff)});
                do_read();
            end
        end
        high_speed = 1'b1;
        divisor = 8'd0;
        repeat (600) @(negedge clk);

        // R3 / R5 nine-bit, no filtering
        nine_bit = 1'b1;
        for (int v = 0; v < 512; v += 7) begin
            send(9'(v), 1'b1, 1'b1);
            check("R3 nine", {rx_ready, rx_bit9, rx_data}, {1'b1, 9'(v)});
            do_read();
        end

        // R4 address filtering
        addr_detect = 1'b1;
        for (int v = 0; v < 512; v += 13) begin
            send(9'(v), 1'b1, 1'b1);
            if (v >= 256) begin
                check("R4 keep", {rx_ready, rx_bit9, rx_data}, {1'b1, 9'(v)});
                do_read();
            end else begin
                check("R4 drop", rx_ready, 0);
            end
        end

        // R5 filter inert in 8-bit mode
        nine_bit = 1'b0;
        send(9'h05A, 1'b0, 1'b1);
        check("R5 eight-bit with filter", {rx_ready, rx_bit9, rx_data}, {2'b10, 8'h5A});
        do_read();
        addr_detect = 1'b0;

        // R6 framing error follows its entry
        send(9'h0C3, 1'b0, 1'b0);
        send(9'h03C, 1'b0, 1'b1);
        check("R6 bad stop", {rx_ready, ferr, rx_data}, {2'b11, 8'hC3});
        do_read();
        check("R6 next entry", {rx_ready, ferr, rx_data}, {2'b10, 8'h3C});
        do_read();

        // R9 glitch rejection
        @(negedge clk) rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (400) @(negedge clk);
        check("R9 glitch", rx_ready, 0);
        send(9'h0A5, 1'b0, 1'b1);
        check("R9 after glitch", {rx_ready, rx_data}, {1'b1, 8'hA5});
        do_read();

        // R8 overrun
        send(9'h011, 1'b0, 1'b1);
        send(9'h022, 1'b0, 1'b1);
        check("R8 full no oerr", {rx_ready, oerr, rx_data}, {2'b10, 8'h11});
        send(9'h033, 1'b0, 1'b1);
        check("R8 oerr set", {rx_ready, oerr, rx_data}, {2'b11, 8'h11});
        do_read();
        check("R7 order second", {rx_ready, rx_data}, {1'b1, 8'h22});
        do_read();
        check("R8 third lost", {rx_ready, oerr}, 2'b01);
        do_read();
        check("R7 empty read keeps oerr", {rx_ready, oerr}, 2'b01);
        send(9'h044, 1'b0, 1'b1);
        check("R8 locked", {rx_ready, oerr}, 2'b01);
        @(negedge clk) rx_enable = 1'b0;
        @(negedge clk) rx_enable = 1'b1;
        @(negedge clk);
        check("R8 cleared", oerr, 0);
        send(9'h055, 1'b0, 1'b1);
        check("R8 resumed", {rx_ready, rx_data}, {1'b1, 8'h55});
        do_read();

        // R10 disabled
        rx_enable = 1'b0;
        send(9'h066, 1'b0, 1'b1);
        check("R10 disabled", rx_ready, 0);
        rx_enable = 1'b1;
        repeat (40) @(negedge clk);
        send(9'h077, 1'b0, 1'b1);
        check("R10 reenabled", {rx_ready, rx_data}, {1'b1, 8'h77});
        do_read();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule